// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs Clause 22 management frames from a host to an external PHY over the two-wire MDC/MDIO link. A small register bus reaches two 16-bit registers: a command word and a data word. The command word packs the PHY address, the register number, a divider-select code, the transfer direction and a self-clearing start/busy flag. MDC comes from the system clock through a divider that the select code chooses. MDIO is brought out as separate output, output-enable and input pins, which the pad ring joins into one tri-state pin.

For a write transfer the host first loads the data word and then writes the command word with the start flag set. For a read transfer it writes only the command word. In both cases the host polls the command word until the busy flag drops. After a read, the PHY's answer is then in the data word. The host must not issue a new command while busy is high.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Bus address 0 selects the command word and bus address 1 the data word. The command word reads back as PHY address in bits 15:11, register number in 10:6, divider code in 5:2, direction in bit 1 (1 = write, 0 = read) and busy in bit 0. Reads are combinational.
- R2: A command write with bit 0 set starts a frame, and busy reads 1 from the next cycle. Busy clears by itself after the last frame bit. A command write with bit 0 clear only stores the fields and starts no frame.
- R3: Each frame carries, MSB first, PREAMBLE_LEN ones, the start pattern 01, the opcode (10 for read, 01 for write), the 5-bit PHY address and the 5-bit register number. Then come 2 turnaround bits and 16 data bits. In a write frame the turnaround is 10 and the data bits are the contents of the data word.
- R4: In a read frame the master releases MDIO (output enable 0) for both turnaround bits and all 16 data bits. It samples MDIO on the rising edge of MDC, and the captured value is in the data word when busy clears.
- R5: MDIO output and output enable change only when MDC falls, or at frame start while MDC is low. MDC stays low whenever no frame is running.
- R6: The divider code sets the MDC period in system clocks: 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102 and 5 gives 124. Codes 6 to 15 give 124. MDC is high for half the period and low for the other half.
- R7: While busy is 1, writes to either the command word or the data word are ignored. The running frame and the register contents are unchanged.
- R8: After reset busy is 0, both words read 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 command, 1 data |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for the selected word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, 1 drives the pin |
| mdio_i | input | 1 | MDIO input from the pin |

## Verification
The bench builds the block with PREAMBLE_LEN set to 8, which brings the frame down to 40 bits. This makes it cheap to run every named divider code and two fallback codes (9 and 15) on full frames, and to measure each MDC period against its ratio from the edge timestamps. A PHY model in the bench decodes each frame from the pins and answers reads with a value derived from the address and register fields. The bench also injects command and data writes in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int SEL_W   = 4;
  localparam int DATA_W  = 16;
  localparam int RATIO_W = 7;
  localparam int RATIO_MAX = 124;
  localparam int HALF_W  = $clog2(RATIO_MAX / 2 + 1);

  localparam logic ADDR_CMD  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regad;
    logic [SEL_W-1:0] csel;
    logic             wr;
  } mdio_cmd_t;

  // MDC period in system clocks for each divider code
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    case (code)
      4'd0:    ratio_of = RATIO_W'(42);
      4'd1:    ratio_of = RATIO_W'(62);
      4'd2:    ratio_of = RATIO_W'(16);
      4'd3:    ratio_of = RATIO_W'(26);
      4'd4:    ratio_of = RATIO_W'(102);
      default: ratio_of = RATIO_W'(RATIO_MAX);
    endcase
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] csel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [RATIO_W-1:0] ratio;
  logic [HALF_W-1:0]  half_m1;
  logic [HALF_W-1:0]  cnt_q, cnt_d;
  logic               mdc_q, mdc_d;
  logic               term;

  assign ratio   = ratio_of(csel);
  assign half_m1 = ratio[RATIO_W-1:1] - HALF_W'(1);
  assign term    = run && (cnt_q == half_m1);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = term & ~mdc_q;
  assign fall_tick = term & mdc_q;

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc_q); // R5
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int FRAME_W = PREAMBLE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_IDX  = PREAMBLE_LEN + 4 + PHY_W + REG_W;
  localparam int DAT_IDX = TA_IDX + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               act_q, act_d;
  logic               rd_q, rd_d;
  logic [DATA_W-1:0]  cap_q, cap_d;
  logic               last_bit;
  logic [1:0]         op_bits, ta_bits;
  logic [DATA_W-1:0]  tx_data;

  assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));
  assign op_bits  = cmd.wr ? 2'b01 : 2'b10;
  assign ta_bits  = cmd.wr ? 2'b10 : 2'b11;
  assign tx_data  = cmd.wr ? wdata : '1;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    act_d = act_q;
    rd_d  = rd_q;
    cap_d = cap_q;
    if (launch) begin
      sh_d  = {{PREAMBLE_LEN{1'b1}}, 2'b01, op_bits, cmd.phy, cmd.regad, ta_bits, tx_data};
      idx_d = '0;
      act_d = 1'b1;
      rd_d  = ~cmd.wr;
    end else if (act_q && fall_tick) begin
      if (last_bit) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
        sh_d  = {sh_q[FRAME_W-2:0], 1'b1};
      end
    end
    if (act_q && rd_q && rise_tick && (idx_q >= IDX_W'(DAT_IDX))) begin
      cap_d = {cap_q[DATA_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      idx_q <= '0;
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
      act_q <= act_d;
      rd_q  <= rd_d;
      cap_q <= cap_d;
    end
  end

  assign mdio_o  = act_q ? sh_q[FRAME_W-1] : 1'b1;
  assign mdio_oe = act_q & ~(rd_q & (idx_q >= IDX_W'(TA_IDX)));
  assign active  = act_q;
  assign done    = act_q & fall_tick & last_bit;
  assign rdata   = cap_q;

  AST_PREAMBLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && idx_q < IDX_W'(PREAMBLE_LEN)) |-> (mdio_o && mdio_oe)); // R3
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !launch); // R7
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] bus_rdata,
  output mdio_cmd_t         cmd,
  output logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              launch
);
  mdio_cmd_t         cmd_q, cmd_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              busy_q, busy_d;
  logic              launch_q, launch_d;
  logic              cmd_we, dat_we;

  assign cmd_we = bus_wr && (bus_addr == ADDR_CMD) && !busy_q;
  assign dat_we = bus_wr && (bus_addr == ADDR_DATA) && !busy_q;

  always_comb begin
    cmd_d    = cmd_q;
    dat_d    = dat_q;
    busy_d   = busy_q;
    launch_d = 1'b0;
    if (cmd_we) begin
      cmd_d    = bus_wdata[DATA_W-1:1];
      busy_d   = bus_wdata[0];
      launch_d = bus_wdata[0];
    end else if (done) begin
      busy_d = 1'b0;
      if (!cmd_q.wr) dat_d = rx_data;
    end
    if (dat_we) dat_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      dat_q    <= '0;
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      dat_q    <= dat_d;
      busy_q   <= busy_d;
      launch_q <= launch_d;
    end
  end

  assign bus_rdata = (bus_addr == ADDR_CMD) ? {cmd_q, busy_q} : dat_q;
  assign cmd       = cmd_q;
  assign data      = dat_q;
  assign busy      = busy_q;
  assign launch    = launch_q;

  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_wr && bus_addr == ADDR_CMD) |=> $stable(cmd_q)); // R7
  AST_BUSY_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done)); // R2
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t         cmd;
  logic [DATA_W-1:0] data, rx_data;
  logic              busy, launch, done, active;
  logic              rise_tick, fall_tick;

  mdio_mgmt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .done(done), .rx_data(rx_data),
    .bus_rdata(bus_rdata), .cmd(cmd), .data(data), .busy(busy), .launch(launch)
  );

  mdio_mdc_gen u_mdc (
    .clk(clk), .rst_n(rst_n), .run(active), .csel(cmd.csel),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd), .wdata(data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .active(active), .done(done),
    .rdata(rx_data)
  );

  AST_MDIO_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy); // R8
  AST_MDC_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R5
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int P  = 8;
  localparam int FW = P + 32;

  typedef struct {
    bit          wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    int          ratio;
  } exp_t;

  logic        clk, rst_n, bus_wr, bus_addr, mdio_i;
  logic [15:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  int          checks, errors;
  exp_t        q[$];

  mdio_mgmt_master #(.PREAMBLE_LEN(P)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return {3'b101, p, r, 3'b010};
  endfunction

  function automatic int ratio_exp(input int code);
    case (code)
      0: return 42;  1: return 62;  2: return 16;
      3: return 26;  4: return 102; default: return 124;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 40000; i++) begin
      bus_read(1'b0, v);
      if (!v[0]) break;
    end
  endtask

  // driver: issue one command and push its expected frame
  task automatic run_cmd(input bit wr, input logic [4:0] p, input logic [4:0] r,
                         input int code, input logic [15:0] d);
    logic [15:0] v;
    exp_t e;
    if (wr) bus_write(1'b1, d);
    e.wr = wr; e.phy = p; e.rg = r; e.data = d; e.ratio = ratio_exp(code);
    q.push_back(e);
    bus_write(1'b0, {p, r, 4'(code), wr, 1'b1});
    bus_read(1'b0, v);
    chk(v[0] == 1'b1, "R2", "busy after start", 64'(v[0]), 64'd1);
    wait_idle();
    bus_read(1'b0, v);
    chk(v == {p, r, 4'(code), wr, 1'b0}, "R1", "command readback", 64'(v),
        64'({p, r, 4'(code), wr, 1'b0}));
    if (!wr) begin
      bus_read(1'b1, v);
      chk(v == phy_val(p, r), "R4", "read data", 64'(v), 64'(phy_val(p, r)));
    end
  endtask

  // monitor + PHY model
  initial begin
    logic [FW-1:0] cap, oem;
    logic [15:0]   val;
    bit            rd;
    realtime       t0, tl;
    exp_t          e;
    mdio_i = 1'b1;
    forever begin
      rd = 1'b0; val = '0; t0 = 0; tl = 0;
      for (int k = 0; k < FW; k++) begin
        @(posedge mdc);
        cap[FW-1-k] = mdio_o;
        oem[FW-1-k] = mdio_oe;
        if (k == 0) t0 = $realtime;
        tl = $realtime;
        if (k == P + 3) rd = (cap[FW-1-P-2 -: 2] == 2'b10);
        if (k == P + 13) val = phy_val(cap[FW-1-P-4 -: 5], cap[FW-1-P-9 -: 5]);
        @(negedge mdc);
        if (rd && (k + 1 >= P + 16) && (k + 1 < FW)) mdio_i = val[15-(k+1-P-16)];
        else mdio_i = 1'b1;
      end
      if (q.size() == 0) begin
        chk(1'b0, "R2", "unexpected frame", 64'd1, 64'd0);
      end else begin
        e = q.pop_front();
        chk(cap[FW-1 -: P] == '1 && oem[FW-1 -: P+14] == '1, "R3", "preamble/header driven",
            64'(oem[FW-1 -: P+14]), 64'((1 << (P+14)) - 1));
        chk(cap[FW-1-P -: 2] == 2'b01, "R3", "start bits", 64'(cap[FW-1-P -: 2]), 64'd1);
        chk(cap[FW-1-P-2 -: 2] == (e.wr ? 2'b01 : 2'b10), "R3", "opcode",
            64'(cap[FW-1-P-2 -: 2]), 64'(e.wr ? 2'b01 : 2'b10));
        chk({cap[FW-1-P-4 -: 5], cap[FW-1-P-9 -: 5]} == {e.phy, e.rg}, "R3", "phy/reg fields",
            64'({cap[FW-1-P-4 -: 5], cap[FW-1-P-9 -: 5]}), 64'({e.phy, e.rg}));
        if (e.wr) begin
          chk(cap[17:16] == 2'b10 && oem[17:0] == '1, "R3", "write turnaround",
              64'({oem[17:16], cap[17:16]}), 64'b1110);
          chk(cap[15:0] == e.data, "R3", "write data", 64'(cap[15:0]), 64'(e.data));
        end else begin
          chk(oem[17:0] == '0, "R4", "read release", 64'(oem[17:0]), 64'd0);
        end
        chk(int'((tl - t0) / 8.0) == (FW - 1) * e.ratio, "R6", "mdc period",
            64'(int'((tl - t0) / 8.0)), 64'((FW - 1) * e.ratio));
      end
    end
  end

  initial begin
    logic [15:0] v;
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        // R8 reset state
        bus_read(1'b0, v);
        chk(v == 16'h0, "R8", "command after reset", 64'(v), 64'd0);
        bus_read(1'b1, v);
        chk(v == 16'h0, "R8", "data after reset", 64'(v), 64'd0);
        chk(!mdc && !mdio_oe, "R8", "mdc low, mdio released", 64'({mdc, mdio_oe}), 64'd0);

        // R6 each divider code, alternating R3 writes and R4 reads
        run_cmd(1'b1, 5'h01, 5'h00, 0, 16'hA5C3);
        run_cmd(1'b0, 5'h1F, 5'h1F, 1, 16'h0);
        run_cmd(1'b1, 5'h10, 5'h01, 2, 16'h8000);
        run_cmd(1'b0, 5'h00, 5'h02, 3, 16'h0);
        run_cmd(1'b1, 5'h0A, 5'h15, 4, 16'h0001);
        run_cmd(1'b0, 5'h15, 5'h0A, 5, 16'h0);
        run_cmd(1'b1, 5'h03, 5'h1C, 9, 16'hFFFF);  // fallback code, R6
        run_cmd(1'b0, 5'h1E, 5'h11, 15, 16'h0);    // fallback code, R6

        // R2 command write with bit 0 clear: fields stored, no frame
        bus_write(1'b0, {5'h07, 5'h09, 4'd2, 1'b1, 1'b0});
        repeat (60) begin
          @(negedge clk);
          if (mdc) break;
        end
        chk(!mdc, "R2", "no mdc without start", 64'(mdc), 64'd0);
        bus_read(1'b0, v);
        chk(v == {5'h07, 5'h09, 4'd2, 1'b1, 1'b0}, "R1", "store-only readback",
            64'(v), 64'({5'h07, 5'h09, 4'd2, 1'b1, 1'b0}));

        // R7 writes during a busy write frame are ignored
        begin
          exp_t e;
          bus_write(1'b1, 16'h5A3C);
          e.wr = 1'b1; e.phy = 5'h12; e.rg = 5'h04; e.data = 16'h5A3C; e.ratio = 16;
          q.push_back(e);
          bus_write(1'b0, {5'h12, 5'h04, 4'd2, 1'b1, 1'b1});
          repeat (200) @(negedge clk);
          bus_write(1'b0, {5'h01, 5'h02, 4'd5, 1'b0, 1'b1});
          bus_write(1'b1, 16'h1234);
          wait_idle();
          bus_read(1'b0, v);
          chk(v == {5'h12, 5'h04, 4'd2, 1'b1, 1'b0}, "R7", "command kept",
              64'(v), 64'({5'h12, 5'h04, 4'd2, 1'b1, 1'b0}));
          bus_read(1'b1, v);
          chk(v == 16'h5A3C, "R7", "data kept", 64'(v), 64'h5A3C);
          repeat (200) @(negedge clk);
          chk(!mdc && !mdio_oe, "R7", "no second frame", 64'({mdc, mdio_oe}), 64'd0);
        end
        chk(q.size() == 0, "R2", "all frames seen", 64'(q.size()), 64'd0);
      end
      begin
        #(200000 * 8);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule